// File: doc/BRIEF.md
# USB Packet-End Timeout Generator

This block closes a short USB packet on its own when the local transmit stream stops. It runs in the interface clock domain of the USB bridge chip. It watches four things: the empty indication of the local transmit FIFO, the empty flag of the bridge's currently selected transmit endpoint, the endpoint select bus and the byte write strobe into the bridge. Once the local FIFO has stayed empty for a programmed number of cycles while the endpoint still holds bytes, the block raises a one-cycle packet-end pulse. That pulse commits the partial packet, so the host receives a packet shorter than the 512-byte full size instead of waiting for more data.

The timeout is a static 15-bit input from 0 to 32767 cycles. A value of 0 turns the feature off. The idle count restarts on any of these conditions: the local FIFO holds data, a byte is written, the endpoint is empty, or the select bus points at the receive endpoint. The last condition keeps a short packet from being committed while the bus is busy receiving.

A three-state machine runs the sequence:
- QUIET: nothing has been written since reset or since the last commit. A write strobe to a transmit endpoint (QUIET→TIMING) starts the timing.
- TIMING: the idle counter runs. It goes TIMING→FIRE when the count reaches the timeout.
- FIRE: the pulse is driven. It returns FIRE→QUIET if the pulse was issued. If a write strobe or a receive-endpoint select blocks the pulse in that cycle, it goes FIRE→TIMING and the count starts again from zero.

Top module: `pktend_timer`

## Requirements
- R1: While `rst_n` is low and afterwards, `pkt_end` stays 0 until at least one write strobe with a transmit endpoint selected has occurred.
- R2: An idle cycle is one in which all of the following hold: `txq_empty`=1, `ep_empty`=0, `ep_sel` is 0, 1 or 2, and `wr_strobe`=0. Let a write strobe be sampled on rising edge k, with timeout T>0, followed by idle cycles. Then `pkt_end` is high from edge k+T to edge k+T+1.
- R3: A cycle with `txq_empty`=0 restarts the idle count from zero.
- R4: `ep_sel`=3 selects the receive endpoint. A cycle with that select restarts the idle count, and `pkt_end` is never high while it is selected.
- R5: A cycle with `ep_empty`=1 restarts the idle count.
- R6: A timeout of 0 disables the pulse entirely.
- R7: `pkt_end` is high for exactly one cycle. After it, no further pulse occurs until a new write strobe to a transmit endpoint.
- R8: `pkt_end` is never high in a cycle with `wr_strobe`=1. A pulse blocked this way is withheld, and the count restarts so that a pulse follows T idle cycles later.
- R9: The full 15-bit range is honoured: with T=32767, the pulse comes 32767 idle cycles after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timeout_cycles | input | 15 | Idle cycles before commit; 0 disables |
| txq_empty | input | 1 | Local transmit FIFO is empty |
| ep_empty | input | 1 | Bridge's selected transmit endpoint is empty |
| ep_sel | input | 2 | Endpoint select; 0..2 transmit, 3 receive |
| wr_strobe | input | 1 | Byte written into the bridge this cycle |
| pkt_end | output | 1 | One-cycle packet commit pulse |

## Verification
The pulse comes from the FIRE state, which is entered on the rising edge that completes the T-th idle cycle. The same-cycle write strobe and endpoint select gate it combinationally, so it is due in the cycle that starts at edge k+T and can be suppressed within that cycle. The bench changes inputs on the falling edge and samples `pkt_end` 1 ns later, before the next rising edge. It compares each sample with a cycle model that advances once per rising edge. Directed latency checks count idle cycles after the write and expect the pulse on idle cycle T+1, counting from the write cycle's edge.

// File: rtl/pktend_pkg.sv
package pktend_pkg;
    typedef enum logic [1:0] {
        ST_QUIET  = 2'd0,
        ST_TIMING = 2'd1,
        ST_FIRE   = 2'd2
    } pe_state_t;
endpackage

// File: rtl/pktend_qual.sv
// Decodes per-cycle conditions from the bridge-side inputs.
module pktend_qual #(
    parameter int TW    = 15,
    parameter int SEL_W = 2,
    parameter logic [SEL_W-1:0] RX_SEL = '1
) (
    input  logic [TW-1:0]    timeout_cycles,
    input  logic             txq_empty,
    input  logic             ep_empty,
    input  logic [SEL_W-1:0] ep_sel,
    input  logic             wr_strobe,
    output logic             rx_sel,
    output logic             data_wr,
    output logic             idle_ok,
    output logic             fire_ok
);
    always_comb begin
        rx_sel  = (ep_sel == RX_SEL);
        data_wr = wr_strobe && !rx_sel;
        idle_ok = txq_empty && !ep_empty && !rx_sel && !wr_strobe
                  && (timeout_cycles != '0);
        fire_ok = !wr_strobe && !rx_sel;
    end
endmodule

// File: rtl/pktend_idle_cnt.sv
// Counts consecutive idle cycles; any non-counting cycle clears it.
module pktend_idle_cnt #(
    parameter int TW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt_q;
    logic [TW:0]   cnt_nxt;

    always_comb begin
        cnt_nxt = {1'b0, cnt_q} + 1'b1;
        expired = inc && (limit != '0) && (cnt_nxt >= {1'b0, limit});
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!inc || expired)
            cnt_q <= '0;
        else
            cnt_q <= cnt_nxt[TW-1:0];
    end
endmodule

// File: rtl/pktend_fsm.sv
// QUIET -> TIMING -> FIRE sequencing and pulse output.
module pktend_fsm
    import pktend_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic data_wr,
    input  logic idle_ok,
    input  logic fire_ok,
    input  logic expired,
    output logic count_en,
    output logic pkt_end
);
    pe_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_QUIET;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:  if (data_wr) state_d = ST_TIMING;
            ST_TIMING: if (expired) state_d = ST_FIRE;
            ST_FIRE:   state_d = fire_ok ? ST_QUIET : ST_TIMING;
            default:   state_d = ST_QUIET;
        endcase
    end

    always_comb begin
        count_en = (state_q == ST_TIMING) && idle_ok;
        pkt_end  = (state_q == ST_FIRE) && fire_ok;
    end
endmodule

// File: rtl/pktend_timer.sv
module pktend_timer #(
    parameter int TW    = 15,
    parameter int SEL_W = 2,
    parameter logic [SEL_W-1:0] RX_SEL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TW-1:0]    timeout_cycles,
    input  logic             txq_empty,
    input  logic             ep_empty,
    input  logic [SEL_W-1:0] ep_sel,
    input  logic             wr_strobe,
    output logic             pkt_end
);
    logic rx_sel, data_wr, idle_ok, fire_ok, expired, count_en;

    pktend_qual #(.TW(TW), .SEL_W(SEL_W), .RX_SEL(RX_SEL)) u_qual (
        .timeout_cycles(timeout_cycles),
        .txq_empty     (txq_empty),
        .ep_empty      (ep_empty),
        .ep_sel        (ep_sel),
        .wr_strobe     (wr_strobe),
        .rx_sel        (rx_sel),
        .data_wr       (data_wr),
        .idle_ok       (idle_ok),
        .fire_ok       (fire_ok)
    );

    pktend_idle_cnt #(.TW(TW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (count_en),
        .limit  (timeout_cycles),
        .expired(expired)
    );

    pktend_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_wr (data_wr),
        .idle_ok (idle_ok),
        .fire_ok (fire_ok),
        .expired (expired),
        .count_en(count_en),
        .pkt_end (pkt_end)
    );
endmodule

// File: rtl/pktend_timer_chk.sv
module pktend_timer_chk #(
    parameter int TW    = 15,
    parameter int SEL_W = 2,
    parameter logic [SEL_W-1:0] RX_SEL = '1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [TW-1:0]    timeout_cycles,
    input logic             txq_empty,
    input logic             ep_empty,
    input logic [SEL_W-1:0] ep_sel,
    input logic             wr_strobe,
    input logic             pkt_end
);
    logic written_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            written_q <= 1'b0;
        else if (wr_strobe && ep_sel != RX_SEL)
            written_q <= 1'b1;
        else if (pkt_end)
            written_q <= 1'b0;
    end

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |=> !pkt_end);

    // R7
    needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |-> written_q);

    // R8
    no_wr_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |-> !wr_strobe);

    // R4
    no_rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |-> (ep_sel != RX_SEL));

    // R2
    idle_before_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |-> $past(txq_empty && !ep_empty));

    // R6
    disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_cycles == '0 && $stable(timeout_cycles)) |-> !pkt_end);
endmodule

bind pktend_timer pktend_timer_chk #(.TW(TW), .SEL_W(SEL_W), .RX_SEL(RX_SEL)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .timeout_cycles(timeout_cycles),
    .txq_empty     (txq_empty),
    .ep_empty      (ep_empty),
    .ep_sel        (ep_sel),
    .wr_strobe     (wr_strobe),
    .pkt_end       (pkt_end)
);

// File: tb/pktend_timer_test.sv
`timescale 1ns/1ps
module pktend_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] tmo = '0;
    logic        txe = 1'b1;
    logic        epe = 1'b1;
    logic [1:0]  sel = 2'd0;
    logic        wr = 1'b0;
    logic        pkt_end;

    int    n_tests = 0;
    int    n_fail = 0;
    int    cyc_n = 0;
    string req = "R1";
    int    m_st = 0;   // 0 quiet, 1 timing, 2 fire
    int    m_cnt = 0;
    bit    last_pe = 1'b0;

    always #2 clk = ~clk;

    pktend_timer uut (
        .clk(clk), .rst_n(rst_n), .timeout_cycles(tmo), .txq_empty(txe),
        .ep_empty(epe), .ep_sel(sel), .wr_strobe(wr), .pkt_end(pkt_end)
    );

    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n > 150000) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired (%s): actual running, expected done", req);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic bit exp_pe();
        return (m_st == 2) && !wr && (sel != 2'd3);
    endfunction

    task automatic check(string r, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", r, cyc_n, act, exp);
        end
    endtask

    task automatic step(bit w, bit te, bit ee, logic [1:0] s);
        bit idle;
        wr = w; txe = te; epe = ee; sel = s;
        #1;
        last_pe = pkt_end;
        check(req, pkt_end, exp_pe());
        @(posedge clk);
        idle = te && !ee && (s != 2'd3) && !w && (tmo != 0);
        case (m_st)
            0: if (w && s != 2'd3) begin m_st = 1; m_cnt = 0; end
            1: begin
                if (idle) begin
                    if (m_cnt + 1 >= int'(tmo)) begin m_st = 2; m_cnt = 0; end
                    else m_cnt++;
                end else m_cnt = 0;
            end
            default: begin
                m_st = (!w && s != 2'd3) ? 0 : 1;
                m_cnt = 0;
            end
        endcase
        @(negedge clk);
    endtask

    task automatic idle_n(int n);
        for (int i = 0; i < n; i++) step(0, 1, 0, 2'd1);
    endtask

    // returns the idle-cycle index at which the pulse was first seen, 0 if none
    task automatic find_pulse(int maxn, output int at);
        at = 0;
        for (int i = 1; i <= maxn; i++) begin
            step(0, 1, 0, 2'd1);
            if (last_pe && at == 0) at = i;
        end
    endtask

    initial begin
        int at;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check("R1", pkt_end, 0);
        rst_n = 1'b1;

        // R1: idle with endpoint non-empty but no write yet
        req = "R1"; tmo = 15'd3;
        find_pulse(20, at);
        check("R1", at, 0);

        // R2: latency
        req = "R2"; tmo = 15'd5;
        step(1, 1, 0, 2'd1);
        find_pulse(10, at);
        check("R2", at, 6);

        // R7: no second pulse without a write
        req = "R7";
        find_pulse(30, at);
        check("R7", at, 0);

        // R3: local FIFO data restarts the count
        req = "R3"; tmo = 15'd4;
        step(1, 1, 0, 2'd0);
        idle_n(3);
        step(0, 0, 0, 2'd0);
        find_pulse(10, at);
        check("R3", at, 5);

        // R4: receive select restarts and blocks
        req = "R4"; tmo = 15'd4;
        step(1, 1, 0, 2'd2);
        idle_n(3);
        for (int i = 0; i < 6; i++) step(0, 1, 0, 2'd3);
        find_pulse(10, at);
        check("R4", at, 5);

        // R5: empty endpoint restarts the count
        req = "R5"; tmo = 15'd4;
        step(1, 1, 0, 2'd1);
        idle_n(2);
        step(0, 1, 1, 2'd1);
        find_pulse(10, at);
        check("R5", at, 5);

        // R6: timeout zero disables
        req = "R6"; tmo = 15'd0;
        step(1, 1, 0, 2'd1);
        find_pulse(50, at);
        check("R6", at, 0);

        // R8: write in the fire cycle withholds the pulse
        req = "R8"; tmo = 15'd4;
        step(1, 1, 0, 2'd1);  // FIRE state left pending from R6? no: state timing
        idle_n(4);
        step(1, 1, 0, 2'd1);
        check("R8", last_pe, 0);
        find_pulse(10, at);
        check("R8", at, 5);

        // R9: full-range timeout
        req = "R9"; tmo = 15'd32767;
        step(1, 1, 0, 2'd0);
        find_pulse(32800, at);
        check("R9", at, 32768);

        // R2: constrained random mix
        req = "R2";
        for (int i = 0; i < 4000; i++) begin
            bit w, te, ee;
            logic [1:0] s;
            if (i % 400 == 0) tmo = 15'($urandom_range(12, 0));
            w  = ($urandom_range(4, 0) == 0);
            te = ($urandom_range(5, 0) != 0);
            ee = ($urandom_range(7, 0) == 0);
            s  = ($urandom_range(9, 0) == 0) ? 2'd3 : 2'($urandom_range(2, 0));
            step(w, te, ee, s);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule